// File: doc/BRIEF.md
# SPI Slave with Shift-Through Underrun

This block is the receive and transmit side of a serial peripheral link. An external master supplies the bit clock, so the block has no baud generator of its own. Each of the pins `sck_i`, `cs_ni` and `mosi_i` passes through a two-flop synchronizer into the system clock domain, and the clock edges are detected in that domain. Frames are SPI mode 0 (clock idles low, data sampled on the rising edge, output changed on the falling edge), MSB first. The frame width is set by a parameter.

On the register side, software writes outgoing words into a one-deep transmit buffer and reads incoming words from a one-deep receive register. The block reports buffer-empty, buffer-full, end-of-transmission and overrun through flags. The transmit word moves into the shift register at select assertion, or at the final falling clock edge of a frame. If no word is pending at that point, nothing is loaded. The shift register then keeps shifting, so during the next frame the bits received in the previous frame go back out unchanged.

When select is released in the middle of a frame, the frame is dropped. The bit counter restarts, the shift register is cleared and no receive event is raised. Writing a transmit word never starts a transfer. Only clock edges from the master while select is low move data.

Top module: `spi_slv`

## Requirements
- R1: No clock edge changes state while the synchronized select is high or `en_i` is 0. Under these conditions no frame completes and `rx_full_o` is unchanged.
- R2: Mode 0, MSB first. `miso_o` shows bit FRAME_W-1 of the loaded word before the first rising `sck_i`, and moves to the next bit after each falling edge. `mosi_i` is sampled on the rising edge, and the first sampled bit lands in bit FRAME_W-1 of `rx_data_o`.
- R3: `tx_empty_o` is 1 after reset. A `tx_wr_i` pulse with `en_i` at 1 clears it. Writes with `en_i` at 0 are ignored. It sets again when the pending word moves into the shift register, either at select assertion or at the last falling edge of a frame. A write alone starts no transfer.
- R4: If no word is pending at the last falling edge of a frame, nothing is reloaded. The next frame sends out the word received in the frame just ended, MSB first.
- R5: `rx_full_o` sets when the last bit of a frame is sampled, with the received word in `rx_data_o`. A one-cycle `rx_rd_i` clears it. `rx_data_o` changes only on frame completion.
- R6: `overrun_o` sets when a frame completes while `rx_full_o` is 1 and no read occurs in that cycle. The new word overwrites `rx_data_o`. `rx_rd_i` clears `overrun_o`.
- R7: Select going high in mid-frame discards the partial frame. No `rx_full_o` results. The bit count restarts at zero and the shift register is cleared, so with no word pending the next frame sends zeros.
- R8: `tx_end_o` sets at the last falling edge of a frame when no transmit word is pending. An accepted transmit write clears it.
- R9: `miso_oe_o` is 1 only while `en_i` is 1 and the synchronized select is low. The output is treated as high impedance otherwise.
- R10: Frames are received whether or not any transmit word was written. Receive-only use needs no dummy writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable |
| sck_i | input | 1 | Serial clock from master |
| cs_ni | input | 1 | Select from master, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| tx_wr_i | input | 1 | Transmit buffer write strobe |
| tx_data_i | input | FRAME_W | Transmit word |
| tx_empty_o | output | 1 | Transmit buffer empty |
| tx_end_o | output | 1 | End of transmission |
| rx_rd_i | input | 1 | Receive register read strobe |
| rx_data_o | output | FRAME_W | Last received word |
| rx_full_o | output | 1 | Receive register full |
| overrun_o | output | 1 | Frame arrived while receive register full |

## Verification
A bit counter off by one shows up at the ports within a single frame. `rx_full_o` then rises one clock edge early or late, and `rx_data_o` holds a shifted word. A shift register that is not cleared, or not reloaded, corrupts `miso_o` from the first bit of the next frame, three system clocks after the master's falling edge. The per-clock reference model compares every flag and the data output on every cycle. A wrong flag priority therefore appears on the same edge it occurs, not at the end of a scenario.

// File: rtl/spi_slv_pkg.sv
`timescale 1ns/1ps
package spi_slv_pkg;
  // pin events in the system clock domain
  typedef struct packed {
    logic sck_rise;
    logic sck_fall;
    logic sel_fall;
    logic sel_rise;
    logic sel_low;
    logic mosi;
  } spi_evt_t;
endpackage

// File: rtl/spi_slv_front.sv
`timescale 1ns/1ps
module spi_slv_front
  import spi_slv_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sck_i,
  input  logic     cs_ni,
  input  logic     mosi_i,
  output spi_evt_t evt_o
);
  localparam int unsigned NPIN = 3;
  // pin order {mosi, cs_n, sck}; select idles high
  localparam logic [NPIN-1:0] RST_V = 3'b010;

  logic [NPIN-1:0] pin_raw, pin_sync;
  logic            sck_q, sel_q;

  assign pin_raw = {mosi_i, cs_ni, sck_i};

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_V[p]}};
      else         chain_q <= {chain_q[STAGES-2:0], pin_raw[p]};
    end
    assign pin_sync[p] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      sel_q <= 1'b1;
    end else begin
      sck_q <= pin_sync[0];
      sel_q <= pin_sync[1];
    end
  end

  assign evt_o.sck_rise = pin_sync[0] & ~sck_q;
  assign evt_o.sck_fall = ~pin_sync[0] & sck_q;
  assign evt_o.sel_fall = ~pin_sync[1] & sel_q;
  assign evt_o.sel_rise = pin_sync[1] & ~sel_q;
  assign evt_o.sel_low  = ~pin_sync[1];
  assign evt_o.mosi     = pin_sync[2];
endmodule

// File: rtl/spi_slv_engine.sv
`timescale 1ns/1ps
module spi_slv_engine
  import spi_slv_pkg::*;
#(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  spi_evt_t           evt_i,
  input  logic               tx_pend_i,
  input  logic [FRAME_W-1:0] tx_word_i,
  output logic               miso_o,
  output logic               frame_done_o,
  output logic [FRAME_W-1:0] rx_word_o,
  output logic               word_load_o,
  output logic               tx_end_evt_o
);
  localparam int unsigned     CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               fend_q, bit_q;
  logic               act, load_start, rise_ev, fall_ev, reload;

  assign act        = en_i & evt_i.sel_low;
  assign load_start = act & evt_i.sel_fall & tx_pend_i;
  // select edge wins over a coincident clock edge
  assign rise_ev    = act & ~evt_i.sel_fall & evt_i.sck_rise;
  assign fall_ev    = act & ~evt_i.sel_fall & ~evt_i.sck_rise & evt_i.sck_fall;

  assign frame_done_o = rise_ev & (cnt_q == LAST);
  assign rx_word_o    = {sreg_q[FRAME_W-2:0], evt_i.mosi};
  assign reload       = fall_ev & fend_q & tx_pend_i;
  assign word_load_o  = load_start | reload;
  assign tx_end_evt_o = fall_ev & fend_q & ~tx_pend_i;
  assign miso_o       = sreg_q[FRAME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      fend_q <= 1'b0;
      bit_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      fend_q <= 1'b0;
    end else if (evt_i.sel_rise) begin
      cnt_q  <= '0;
      fend_q <= 1'b0;
      if (cnt_q != '0) sreg_q <= '0;   // abort: drop partial frame
    end else begin
      if (word_load_o)  sreg_q <= tx_word_i;
      else if (fall_ev) sreg_q <= {sreg_q[FRAME_W-2:0], bit_q};  // underrun shifts input through
      if (rise_ev) begin
        bit_q  <= evt_i.mosi;
        cnt_q  <= frame_done_o ? '0 : cnt_q + 1'b1;
        fend_q <= frame_done_o;
      end else if (fall_ev) begin
        fend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_slv_regs.sv
`timescale 1ns/1ps
module spi_slv_regs #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tx_wr_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  input  logic               rx_rd_i,
  input  logic               word_load_i,
  input  logic               tx_end_evt_i,
  input  logic               frame_done_i,
  input  logic [FRAME_W-1:0] rx_word_i,
  output logic [FRAME_W-1:0] tx_word_o,
  output logic               tx_pend_o,
  output logic               tx_empty_o,
  output logic               tx_end_o,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               rx_full_o,
  output logic               overrun_o
);
  logic wr_ok;
  assign wr_ok     = tx_wr_i & en_i;
  assign tx_pend_o = ~tx_empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_word_o  <= '0;
      tx_empty_o <= 1'b1;
      tx_end_o   <= 1'b0;
    end else if (wr_ok) begin
      tx_word_o  <= tx_data_i;
      tx_empty_o <= 1'b0;
      tx_end_o   <= 1'b0;
    end else begin
      if (word_load_i)  tx_empty_o <= 1'b1;
      if (tx_end_evt_i) tx_end_o   <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o <= '0;
      rx_full_o <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      if (frame_done_i) begin
        rx_data_o <= rx_word_i;
        rx_full_o <= 1'b1;
      end else if (rx_rd_i) begin
        rx_full_o <= 1'b0;
      end
      if (frame_done_i && rx_full_o && !rx_rd_i) overrun_o <= 1'b1;
      else if (rx_rd_i)                          overrun_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_slv.sv
`timescale 1ns/1ps
module spi_slv
  import spi_slv_pkg::*;
#(
  parameter int unsigned FRAME_W     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               sck_i,
  input  logic               cs_ni,
  input  logic               mosi_i,
  output logic               miso_o,
  output logic               miso_oe_o,
  input  logic               tx_wr_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  output logic               tx_empty_o,
  output logic               tx_end_o,
  input  logic               rx_rd_i,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               rx_full_o,
  output logic               overrun_o
);
  spi_evt_t           evt;
  logic               frame_done, word_load, tx_end_evt, tx_pend;
  logic [FRAME_W-1:0] rx_word, tx_word;

  spi_slv_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .cs_ni  (cs_ni),
    .mosi_i (mosi_i),
    .evt_o  (evt)
  );

  spi_slv_engine #(.FRAME_W(FRAME_W)) u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .evt_i        (evt),
    .tx_pend_i    (tx_pend),
    .tx_word_i    (tx_word),
    .miso_o       (miso_o),
    .frame_done_o (frame_done),
    .rx_word_o    (rx_word),
    .word_load_o  (word_load),
    .tx_end_evt_o (tx_end_evt)
  );

  spi_slv_regs #(.FRAME_W(FRAME_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .tx_wr_i      (tx_wr_i),
    .tx_data_i    (tx_data_i),
    .rx_rd_i      (rx_rd_i),
    .word_load_i  (word_load),
    .tx_end_evt_i (tx_end_evt),
    .frame_done_i (frame_done),
    .rx_word_i    (rx_word),
    .tx_word_o    (tx_word),
    .tx_pend_o    (tx_pend),
    .tx_empty_o   (tx_empty_o),
    .tx_end_o     (tx_end_o),
    .rx_data_o    (rx_data_o),
    .rx_full_o    (rx_full_o),
    .overrun_o    (overrun_o)
  );

  assign miso_oe_o = en_i & evt.sel_low;
endmodule

// File: rtl/spi_slv_chk.sv
`timescale 1ns/1ps
module spi_slv_chk #(
  parameter int unsigned FRAME_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               cs_ni,
  input logic               tx_wr_i,
  input logic               rx_rd_i,
  input logic               miso_oe_o,
  input logic               tx_empty_o,
  input logic               tx_end_o,
  input logic [FRAME_W-1:0] rx_data_o,
  input logic               rx_full_o,
  input logic               overrun_o,
  input logic               frame_done,
  input logic               word_load
);
  // R9
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2)) |-> !miso_oe_o);
  // R1
  no_frame_deselected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_ni, 2) && $past(cs_ni, 3)) |-> !frame_done);
  // R3
  tx_wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && en_i) |=> !tx_empty_o);
  // R3
  empty_from_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> $past(word_load));
  // R5
  rx_read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && !frame_done) |=> !rx_full_o);
  // R5
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done |=> $stable(rx_data_o));
  // R6
  overrun_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(rx_full_o));
  // R8
  tx_end_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && en_i) |=> !tx_end_o);
endmodule

bind spi_slv spi_slv_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .cs_ni      (cs_ni),
  .tx_wr_i    (tx_wr_i),
  .rx_rd_i    (rx_rd_i),
  .miso_oe_o  (miso_oe_o),
  .tx_empty_o (tx_empty_o),
  .tx_end_o   (tx_end_o),
  .rx_data_o  (rx_data_o),
  .rx_full_o  (rx_full_o),
  .overrun_o  (overrun_o),
  .frame_done (frame_done),
  .word_load  (word_load)
);

// File: tb/spi_slv_bench.sv
`timescale 1ns/1ps
module spi_slv_bench;
  localparam int W  = 16;
  localparam int HP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic en = 1'b1, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic tx_wr = 1'b0, rx_rd = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic miso, miso_oe, tx_empty, tx_end, rx_full, overrun;
  logic [W-1:0] rx_data;

  int checks = 0, fails = 0, wd = 0;
  bit cmp_on = 1'b0;

  spi_slv #(.FRAME_W(W)) u_spi_slv (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .tx_empty_o(tx_empty), .tx_end_o(tx_end), .rx_rd_i(rx_rd), .rx_data_o(rx_data),
    .rx_full_o(rx_full), .overrun_o(overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: pin histories and flag variables
  logic m_sck1, m_sck2, m_sckp, m_cs1, m_cs2, m_csp, m_mo1, m_mo2;
  logic [W-1:0] m_sreg, m_txbuf, m_rxd, m_word;
  int   m_cnt;
  bit   m_fend, m_inb, m_txe, m_tend, m_rxf, m_ovr;
  bit   m_rise, m_fall, m_csf, m_csr, m_done, m_load, m_endv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sck1 = 0; m_sck2 = 0; m_sckp = 0; m_cs1 = 1; m_cs2 = 1; m_csp = 1; m_mo1 = 0; m_mo2 = 0;
      m_sreg = '0; m_txbuf = '0; m_rxd = '0; m_cnt = 0;
      m_fend = 0; m_inb = 0; m_txe = 1; m_tend = 0; m_rxf = 0; m_ovr = 0;
    end else begin
      m_rise = m_sck2 && !m_sckp;  m_fall = !m_sck2 && m_sckp;
      m_csf  = !m_cs2 && m_csp;    m_csr  = m_cs2 && !m_csp;
      m_done = 0; m_load = 0; m_endv = 0; m_word = '0;
      if (!en) begin
        m_cnt = 0; m_fend = 0;
      end else if (m_csr) begin
        if (m_cnt != 0) m_sreg = '0;
        m_cnt = 0; m_fend = 0;
      end else if (!m_cs2) begin
        if (m_csf) begin
          if (!m_txe) begin m_sreg = m_txbuf; m_load = 1; end
        end else if (m_rise) begin
          m_inb = m_mo2;
          if (m_cnt == W - 1) begin
            m_done = 1; m_word = {m_sreg[W-2:0], m_mo2}; m_cnt = 0; m_fend = 1;
          end else m_cnt++;
        end else if (m_fall) begin
          if (m_fend && !m_txe) begin m_sreg = m_txbuf; m_load = 1; end
          else begin m_sreg = {m_sreg[W-2:0], m_inb}; if (m_fend) m_endv = 1; end
          m_fend = 0;
        end
      end
      if (tx_wr && en) begin
        m_txbuf = tx_data; m_txe = 0; m_tend = 0;
      end else begin
        if (m_load) m_txe = 1;
        if (m_endv) m_tend = 1;
      end
      if (m_done) begin
        if (m_rxf && !rx_rd) m_ovr = 1; else if (rx_rd) m_ovr = 0;
        m_rxd = m_word; m_rxf = 1;
      end else if (rx_rd) begin
        m_rxf = 0; m_ovr = 0;
      end
      m_sckp = m_sck2; m_csp = m_cs2;
      m_sck2 = m_sck1; m_cs2 = m_cs1; m_mo2 = m_mo1;
      m_sck1 = sck;    m_cs1 = cs_n;  m_mo1 = mosi;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R9 oe", miso_oe, en && !m_cs2);
      if (miso_oe) chk("R2 miso", miso, m_sreg[W-1]);
      chk("R3 tx_empty", tx_empty, m_txe);
      chk("R8 tx_end", tx_end, m_tend);
      chk("R5 rx_full", rx_full, m_rxf);
      chk("R5 rx_data", rx_data, m_rxd);
      chk("R6 overrun", overrun, m_ovr);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog all-requirements actual=%0d expected<150000", wd);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic write_tx(input logic [W-1:0] d);
    @(negedge clk); tx_wr = 1; tx_data = d;
    @(negedge clk); tx_wr = 0;
  endtask
  task automatic read_rx();
    @(negedge clk); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask
  task automatic select();   @(negedge clk); cs_n = 0; cyc(6); endtask
  task automatic deselect(); @(negedge clk); cs_n = 1; cyc(6); endtask
  task automatic xfer(input logic [W-1:0] mo, input int nbits, output logic [W-1:0] got);
    got = '0;
    for (int i = W - 1; i >= W - nbits; i--) begin
      @(negedge clk); mosi = mo[i];
      cyc(HP); got[i] = miso;
      sck = 1; cyc(HP); sck = 0;
    end
    cyc(HP + 2);
  endtask

  logic [W-1:0] got;

  initial begin
    cyc(3); rst_n = 1; cmp_on = 1;
    @(negedge clk);
    chk("R3 reset tx_empty", tx_empty, 1);
    chk("R5 reset rx_full", rx_full, 0);
    chk("R6 reset overrun", overrun, 0);
    chk("R8 reset tx_end", tx_end, 0);
    chk("R9 reset oe", miso_oe, 0);

    write_tx(16'hA5C3);
    chk("R3 write clears empty", tx_empty, 0);
    cyc(10);
    chk("R3 write starts nothing", rx_full, 0);
    select();
    chk("R3 load at select", tx_empty, 1);
    chk("R9 oe when selected", miso_oe, 1);
    xfer(16'h1234, W, got);
    chk("R2 master sees tx word", got, 16'hA5C3);
    chk("R2 rx word msb first", rx_data, 16'h1234);
    chk("R5 rx_full set", rx_full, 1);
    chk("R8 end of transmission", tx_end, 1);

    xfer(16'hBEEF, W, got);
    chk("R4 shift-through echo", got, 16'h1234);
    chk("R6 overrun set", overrun, 1);
    chk("R6 overwrite", rx_data, 16'hBEEF);
    read_rx();
    chk("R5 read clears full", rx_full, 0);
    chk("R6 read clears overrun", overrun, 0);

    write_tx(16'h0F0F);
    chk("R8 write clears end", tx_end, 0);
    xfer(16'h5555, W, got);
    chk("R4 pending waits frame end", got, 16'hBEEF);
    chk("R3 reload at frame end", tx_empty, 1);
    read_rx();
    xfer(16'h00FF, W, got);
    chk("R3 reloaded word sent", got, 16'h0F0F);
    chk("R8 end after last frame", tx_end, 1);
    read_rx();

    deselect();
    chk("R9 oe off deselected", miso_oe, 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); mosi = k[0]; cyc(HP); sck = 1; cyc(HP); sck = 0;
    end
    cyc(HP);
    chk("R1 clock ignored deselected", rx_full, 0);

    select();
    xfer(16'hFFFF, 7, got);
    deselect();
    chk("R7 abort no rx_full", rx_full, 0);
    select();
    xfer(16'hC33C, W, got);
    chk("R7 cleared shift register", got, 16'h0000);
    chk("R10 receive-only frame", rx_data, 16'hC33C);
    chk("R10 receive-only full", rx_full, 1);
    read_rx();
    deselect();

    en = 0;
    select();
    chk("R9 oe off disabled", miso_oe, 0);
    xfer(16'h1111, W, got);
    chk("R1 disabled no frame", rx_full, 0);
    write_tx(16'h2222);
    chk("R3 write ignored disabled", tx_empty, 1);
    deselect();
    en = 1;
    cyc(4);
    write_tx(16'h3333);
    chk("R8 write clears end", tx_end, 0);
    cyc(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule